// File: doc/BRIEF.md
# Coalescing Update Log for a Locked Lookup Table

This block sits beside a single-bank lookup table whose contents must stay constant while a processing pass reads them. While the table is locked, host writes are held in a small log and not applied to the table. A repeated write to an address already in the log replaces that entry's value, so the log holds one entry per distinct address, carrying the last value written.

When the lock is released, the block walks the log in the order entries were first created and writes one entry per clock cycle into the table. The time needed to release the lock therefore grows with the number of distinct addresses updated, not with the size of the table. Host writes that arrive during this walk keep working. A write to an address whose entry is still waiting updates that entry. Any other write goes straight to the table, and the walk pauses for that cycle. Either way the host's value is the one that stays in the table.

A full flag shows when every log slot is in use. A sticky overflow flag records that a write to a new address was dropped. A one-cycle done pulse marks the end of the walk, and at that point the log is emptied.

Top module: `coalesce_log`

## Requirements
- R1: While unlocked and not writing back, a host write appears on the table write port on the next cycle with the same address and data.
- R2: While locked, host writes produce no table write.
- R3: Several locked writes to one address yield exactly one table write for that address during write-back, carrying the last value written.
- R4: After the lock is released, the block writes each logged entry to the table exactly once, one entry per cycle, in the order the entries were first created.
- R5: `full_o` is high once DEPTH distinct addresses are logged. A write to an address already logged is still merged while the log is full.
- R6: A locked write to a new address while the log is full is dropped and sets `ovf_o`. `ovf_o` stays high until the next lock begins, including through write-back.
- R7: During write-back, a host write to an address whose entry is still pending replaces that entry's value. A write to any other address goes to the table on the next cycle, ahead of the remaining entries. In both cases the host value is the final table content.
- R8: `done_o` is a single-cycle pulse that follows the last write-back write, including when the log is empty. After it, the log is empty, so the next lock starts with `full_o` low.
- R9: A lock raised during write-back takes effect only after `done_o`. Writes made after that point are logged, not written to the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | High holds the table locked; a falling edge starts write-back |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host write address |
| host_data_i | input | DATA_W | Host write data |
| tbl_we_o | output | 1 | Table write enable |
| tbl_addr_o | output | ADDR_W | Table write address |
| tbl_data_o | output | DATA_W | Table write data |
| done_o | output | 1 | One-cycle pulse at the end of write-back |
| full_o | output | 1 | Every log slot is in use |
| ovf_o | output | 1 | Sticky: a write to a new address was dropped |

## Verification
The assertions check four properties on every cycle:
- at most one live log slot matches an incoming address, so coalescing never leaves duplicates;
- a locked cycle never yields a table write;
- the write-back pointer only holds, steps by one or clears;
- `done_o` lasts a single cycle, and `full_o` and `ovf_o` hold until a clear or a new lock.

Three things only the bench scenarios can show: that the table sees the right values in creation order, that merges keep the last value, and that host writes during write-back leave the host's value in place. The same holds for the full and overflow boundary, and for a lock request raised before write-back has finished.

// File: rtl/culog_pkg.sv
package culog_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOCK  = 2'd1,
      ST_FLUSH = 2'd2
   } cl_state_e;
endpackage

// File: rtl/culog_store.sv
module culog_store #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              merge_en,
   input  logic              append_en,
   input  logic [ADDR_W-1:0] key_addr,
   input  logic [DATA_W-1:0] key_data,
   input  logic [CNT_W-1:0]  lo,
   output logic              hit,
   output logic              full,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data
);
   logic [ADDR_W-1:0] ent_addr [DEPTH];
   logic [DATA_W-1:0] ent_data [DEPTH];
   logic [DEPTH-1:0]  match;

   assign full = (count == CNT_W'(DEPTH));
   assign hit  = |match;

   // one slot per entry: live-window address compare plus its storage
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
      assign match[i] = (IDX >= lo) && (IDX < count) && (ent_addr[i] == key_addr);
      always_ff @(posedge clk) begin
         if (append_en && !full && count == IDX) begin
            ent_addr[i] <= key_addr;
            ent_data[i] <= key_data;
         end else if (merge_en && match[i]) begin
            ent_data[i] <= key_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) count <= '0;
      else if (append_en && !full) count <= count + 1'b1;
   end

   always_comb begin
      head_addr = '0;
      head_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (CNT_W'(k) == lo) begin
            head_addr = ent_addr[k];
            head_data = ent_data[k];
         end
      end
   end

   // R3: coalescing leaves at most one live slot per address
   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R5: a full log stays full until it is cleared
   p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clear) |=> full);
endmodule

// File: rtl/culog_ctrl.sv
module culog_ctrl
   import culog_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              host_we_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_data_i,
   input  logic              hit,
   input  logic              full,
   input  logic [CNT_W-1:0]  count,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   output logic [CNT_W-1:0]  lo,
   output logic              merge_en,
   output logic              append_en,
   output logic              clear,
   output logic              tbl_we_o,
   output logic [ADDR_W-1:0] tbl_addr_o,
   output logic [DATA_W-1:0] tbl_data_o,
   output logic              done_o,
   output logic              ovf_o
);
   cl_state_e        st;
   logic [CNT_W-1:0] rd;
   logic             direct, step, finish, enter_lock, drop;

   assign lo         = rd;
   assign merge_en   = host_we_i && hit && (st != ST_IDLE);
   assign append_en  = host_we_i && !hit && !full && (st == ST_LOCK);
   assign drop       = host_we_i && !hit && full && (st == ST_LOCK);
   assign direct     = host_we_i && ((st == ST_IDLE) || (st == ST_FLUSH && !hit));
   assign step       = (st == ST_FLUSH) && !host_we_i && (rd < count);
   assign finish     = (st == ST_FLUSH) && !host_we_i && (rd >= count);
   assign clear      = finish;
   assign enter_lock = ((st == ST_IDLE) && lock_i) || (finish && lock_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         rd         <= '0;
         tbl_we_o   <= 1'b0;
         tbl_addr_o <= '0;
         tbl_data_o <= '0;
         done_o     <= 1'b0;
         ovf_o      <= 1'b0;
      end else begin
         tbl_we_o <= direct || step;
         if (direct) begin
            tbl_addr_o <= host_addr_i;
            tbl_data_o <= host_data_i;
         end else if (step) begin
            tbl_addr_o <= head_addr;
            tbl_data_o <= head_data;
         end
         done_o <= finish;
         if (step) rd <= rd + 1'b1;
         else if (finish) rd <= '0;
         if (enter_lock) ovf_o <= 1'b0;
         else if (drop) ovf_o <= 1'b1;
         unique case (st)
            ST_IDLE:  if (lock_i) st <= ST_LOCK;
            ST_LOCK:  if (!lock_i) st <= ST_FLUSH;
            ST_FLUSH: if (finish) st <= lock_i ? ST_LOCK : ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   // R2: nothing reaches the table from a locked cycle
   p_locked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOCK) |=> !tbl_we_o);

   // R4: the write-back pointer holds, steps by one, or returns to zero
   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLUSH) |=> (rd == $past(rd) || rd == $past(rd) + 1'b1 || rd == '0));

   // R6: overflow flag is sticky outside lock entry
   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !lock_i) |=> ovf_o);

   // R8: done lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9: a lock request does not cut write-back short
   p_lock_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLUSH && rd < count && !host_we_i) |=> (st == ST_FLUSH));
endmodule

// File: rtl/coalesce_log.sv
module coalesce_log #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              host_we_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_data_i,
   output logic              tbl_we_o,
   output logic [ADDR_W-1:0] tbl_addr_o,
   output logic [DATA_W-1:0] tbl_data_o,
   output logic              done_o,
   output logic              full_o,
   output logic              ovf_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("coalesce_log: DEPTH must lie in 2..1024");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("coalesce_log: ADDR_W and DATA_W must be positive");
   end

   logic              hit, full, merge_en, append_en, clear;
   logic [CNT_W-1:0]  count, lo;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data;

   culog_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear), .merge_en(merge_en),
      .append_en(append_en), .key_addr(host_addr_i), .key_data(host_data_i),
      .lo(lo), .hit(hit), .full(full), .count(count),
      .head_addr(head_addr), .head_data(head_data));

   culog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .host_we_i(host_we_i),
      .host_addr_i(host_addr_i), .host_data_i(host_data_i), .hit(hit),
      .full(full), .count(count), .head_addr(head_addr), .head_data(head_data),
      .lo(lo), .merge_en(merge_en), .append_en(append_en), .clear(clear),
      .tbl_we_o(tbl_we_o), .tbl_addr_o(tbl_addr_o), .tbl_data_o(tbl_data_o),
      .done_o(done_o), .ovf_o(ovf_o));

   assign full_o = full;
endmodule

// File: tb/coalesce_log_tb.sv
module coalesce_log_tb;
   localparam int AW = 14;
   localparam int DW = 16;
   localparam int DEPTH = 64;

   logic clk = 1'b0, rst_n = 1'b0, lock_i = 1'b0, host_we_i = 1'b0;
   logic [AW-1:0] host_addr_i = '0;
   logic [DW-1:0] host_data_i = '0;
   logic tbl_we_o, done_o, full_o, ovf_o;
   logic [AW-1:0] tbl_addr_o;
   logic [DW-1:0] tbl_data_o;

   always #2.5 clk = ~clk;

   coalesce_log #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .host_we_i(host_we_i),
      .host_addr_i(host_addr_i), .host_data_i(host_data_i),
      .tbl_we_o(tbl_we_o), .tbl_addr_o(tbl_addr_o), .tbl_data_o(tbl_data_o),
      .done_o(done_o), .full_o(full_o), .ovf_o(ovf_o));

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      bit            is_log;
      string         req;
   } item_t;

   item_t expq[$];
   item_t logq[$];
   int nchk = 0, nerr = 0, nwr = 0, bmode = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every table write
   always @(posedge clk) begin
      #1;
      if (rst_n && tbl_we_o) begin
         nwr++;
         if (expq.size() == 0) begin
            chk(0, "R2", "unexpected table write addr", int'(tbl_addr_o), 0);
         end else begin
            item_t it;
            it = expq.pop_front();
            chk(tbl_addr_o == it.a, it.req, "table write addr", int'(tbl_addr_o), int'(it.a));
            chk(tbl_data_o == it.d, it.req, "table write data", int'(tbl_data_o), int'(it.d));
         end
      end
   end

   // driver: one host write per call, called at a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit found = 0;
      if (bmode == 0) begin
         expq.push_back('{a: a, d: d, is_log: 0, req: "R1"});
      end else if (bmode == 1) begin
         foreach (logq[k]) if (logq[k].a == a) begin logq[k].d = d; logq[k].req = "R3"; found = 1; end
         if (!found && logq.size() < DEPTH) logq.push_back('{a: a, d: d, is_log: 1, req: "R4"});
      end else begin
         foreach (expq[k]) if (expq[k].is_log && expq[k].a == a) begin expq[k].d = d; expq[k].req = "R7"; found = 1; end
         if (!found) expq.push_front('{a: a, d: d, is_log: 0, req: "R7"});
      end
      host_we_i = 1'b1; host_addr_i = a; host_data_i = d;
      @(negedge clk);
      host_we_i = 1'b0;
   endtask

   task automatic do_lock();
      lock_i = 1'b1;
      @(negedge clk);
      bmode = 1;
      logq.delete();
   endtask

   task automatic do_unlock();
      foreach (logq[k]) expq.push_back(logq[k]);
      logq.delete();
      lock_i = 1'b0;
      @(negedge clk);
      bmode = 2;
   endtask

   task automatic wait_done(input string req);
      bit seen = 0;
      for (int c = 0; c < 400 && !seen; c++) begin
         @(posedge clk); #2;
         if (done_o) seen = 1;
      end
      chk(seen, req, "done pulse seen", int'(seen), 1);
      chk(expq.size() == 0, "R4", "entries left after done", expq.size(), 0);
      @(posedge clk); #2;
      chk(!done_o, req, "done lasts one cycle", int'(done_o), 0);
      @(negedge clk);
      bmode = lock_i ? 1 : 0;
      if (lock_i) logq.delete();
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      int w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tbl_we_o && !done_o && !full_o && !ovf_o, "R8", "reset outputs",
          {tbl_we_o, done_o, full_o, ovf_o}, 0);

      // R1: direct writes while unlocked
      wr(14'h0010, 16'h1111);
      wr(14'h0011, 16'h2222);
      wr(14'h3FFF, 16'hFFFF);
      repeat (2) @(negedge clk);

      // R2, R3, R4: locked writes with merges
      do_lock();
      w0 = nwr;
      wr(14'h0100, 16'h0001);
      wr(14'h0200, 16'h0002);
      wr(14'h0100, 16'h0003);
      wr(14'h0300, 16'h0004);
      wr(14'h0200, 16'h0005);
      repeat (3) @(negedge clk);
      chk(nwr == w0, "R2", "table writes while locked", nwr - w0, 0);
      do_unlock();
      wait_done("R8");

      // R8: empty lock still pulses done
      do_lock();
      w0 = nwr;
      do_unlock();
      wait_done("R8");
      chk(nwr == w0, "R8", "writes from empty log", nwr - w0, 0);

      // R5, R6: fill the log
      do_lock();
      for (int i = 0; i < DEPTH; i++) begin
         wr(AW'(100 + 3 * i), DW'(16'h4000 + i));
         if (i == DEPTH - 2) chk(!full_o, "R5", "full one slot early", int'(full_o), 0);
      end
      chk(full_o, "R5", "full at DEPTH entries", int'(full_o), 1);
      wr(AW'(100), 16'hBEEF);
      chk(!ovf_o, "R5", "merge while full sets overflow", int'(ovf_o), 0);
      wr(14'h2000, 16'hDEAD);
      chk(ovf_o, "R6", "overflow on new address", int'(ovf_o), 1);
      chk(full_o, "R6", "still full after drop", int'(full_o), 1);

      // R7: host writes during write-back
      do_unlock();
      @(negedge clk);
      wr(AW'(100 + 3 * 60), 16'h7777);
      wr(14'h3000, 16'h5A5A);
      wr(AW'(100), 16'h6666);
      wait_done("R7");
      chk(ovf_o, "R6", "overflow sticky through write-back", int'(ovf_o), 1);

      // R6, R8: new lock clears overflow and starts an empty log
      do_lock();
      chk(!ovf_o, "R6", "overflow cleared by new lock", int'(ovf_o), 0);
      chk(!full_o, "R8", "log empty after done", int'(full_o), 0);
      wr(14'h0040, 16'h0A0A);
      wr(14'h0041, 16'h0B0B);

      // R9: lock raised during write-back waits for done
      do_unlock();
      lock_i = 1'b1;
      wait_done("R9");
      chk(bmode == 1, "R9", "lock held after done", bmode, 1);
      w0 = nwr;
      wr(14'h0050, 16'h0C0C);
      repeat (3) @(negedge clk);
      chk(nwr == w0, "R9", "writes after deferred lock", nwr - w0, 0);
      do_unlock();
      wait_done("R9");
      repeat (3) @(negedge clk);
      chk(expq.size() == 0, "R4", "scoreboard drained", expq.size(), 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule